// File: doc/BRIEF.md
# Dual 16-bit multiply-accumulate unit

This block computes two signed 16x16 products from a pair of 32-bit operands and folds them into one 32-bit result. The low halves of both operands form one product and the high halves form the other. An optional exchange of the second operand's halves comes first. The two products are either added or the high product is subtracted from the low one. An optional 32-bit accumulator is then added.

The block keeps a sticky saturation flag for the result. The incoming flag value is passed on, and it is raised when the exact signed result does not fit in 32 bits. In the add form with accumulation, overflow is judged once, on the full-width sum of both products and the accumulator. Intermediate partial sums are never checked. One operation is accepted per cycle, and its result appears one cycle later.

Top module: `dual_mac16`

## Requirements
- R1: In add form (`sub_sel`=0, `acc_en`=0), `result` equals the low 32 bits of (opa[15:0]*opb[15:0] + opa[31:16]*opb[31:16]), with every half treated as signed two's complement.
- R2: With `swap_b`=1, the halves of `opb` are exchanged before multiplying: opa[15:0] pairs with opb[31:16], and opa[31:16] pairs with opb[15:0].
- R3: In subtract form (`sub_sel`=1) without accumulation, `result` is the low product minus the high product, and `q_out` equals `q_in`.
- R4: In subtract form with accumulation (`acc_en`=1), the signed `acc` is added to the difference. `q_out` is raised if that signed 32-bit addition overflows.
- R5: In add form without accumulation, `q_out` is raised when the signed sum of the two products does not fit in 32 bits.
- R6: In add form with accumulation, the result is the low 32 bits of the exact sum of both products and `acc`. `q_out` is raised only if that exact sum lies outside [-2^31, 2^31-1]. For example, (-32768*-32768)+(-32768*-32768)+(-1) gives 0x7FFFFFFF with no flag.
- R7: With `acc_en`=0, the value on `acc` has no effect on `result` or `q_out`.
- R8: The flag is sticky: `q_out` = `q_in` OR overflow, so `q_in`=1 always yields `q_out`=1.
- R9: `valid_out` is high exactly one cycle after a cycle with `valid_in` high. While `valid_in` is low, `result` and `q_out` hold their values.
- R10: While reset is applied, `valid_out`, `result` and `q_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| valid_in | input | 1 | Operation request this cycle |
| opa | input | 32 | First operand, two signed halves |
| opb | input | 32 | Second operand, two signed halves |
| acc | input | 32 | Signed accumulator value |
| acc_en | input | 1 | Add the accumulator |
| swap_b | input | 1 | Exchange the halves of opb |
| sub_sel | input | 1 | 1: low product minus high product; 0: sum |
| q_in | input | 1 | Current saturation flag |
| valid_out | output | 1 | Result valid |
| result | output | 32 | Low 32 bits of the exact result |
| q_out | output | 1 | Updated sticky saturation flag |

## Verification
A wrong internal state in this block would be a bad product lane, a truncated wide sum or a misjudged overflow. Any of these shows at `result` or `q_out` in the cycle after the operation is accepted, since there is only one register stage. The overflow boundary is the most fragile part, so it is checked by hand. The cases are the all-minimum-halves sum with and without a -1 accumulator, and a subtraction pushed over the top by the accumulator. Random operands built from the extreme half values then check every combination of controls against a 64-bit model.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

  typedef struct packed {
    logic acc_en;
    logic swap_b;
    logic sub_sel;
  } dmac_ctrl_t;

endpackage

// File: rtl/dmac_rst_sync.sv
module dmac_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/dmac_prod.sv
module dmac_prod #(
  parameter int HALF_W = 16,
  localparam int WORD_W = 2 * HALF_W,
  localparam int PROD_W = 2 * HALF_W
) (
  input  logic [WORD_W-1:0]      opa,
  input  logic [WORD_W-1:0]      opb,
  input  logic                   swap_b,
  output logic [1:0][PROD_W-1:0] prod
);

  logic [WORD_W-1:0] opb_sel;

  always_comb begin
    if (swap_b) opb_sel = {opb[HALF_W-1:0], opb[WORD_W-1:HALF_W]};
    else        opb_sel = opb;
  end

  for (genvar lane = 0; lane < 2; lane++) begin : g_lane
    logic signed [HALF_W-1:0] a_half;
    logic signed [HALF_W-1:0] b_half;
    logic signed [PROD_W-1:0] a_ext;
    logic signed [PROD_W-1:0] b_ext;
    assign a_half = opa[lane*HALF_W +: HALF_W];
    assign b_half = opb_sel[lane*HALF_W +: HALF_W];
    assign a_ext  = PROD_W'(a_half);
    assign b_ext  = PROD_W'(b_half);
    assign prod[lane] = a_ext * b_ext;
  end

endmodule

// File: rtl/dmac_sum.sv
module dmac_sum
  import dmac_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int PROD_W = DATA_W,
  localparam int WIDE_W = DATA_W + 2,
  localparam int TOP_W  = WIDE_W - DATA_W + 1
) (
  input  logic [1:0][PROD_W-1:0] prod,
  input  logic [DATA_W-1:0]      acc,
  input  dmac_ctrl_t             ctrl,
  output logic [DATA_W-1:0]      sum_out,
  output logic                   ovf
);

  logic signed [WIDE_W-1:0] p_lo;
  logic signed [WIDE_W-1:0] p_hi;
  logic signed [WIDE_W-1:0] acc_wide;
  logic signed [WIDE_W-1:0] pair;
  logic signed [WIDE_W-1:0] total;
  logic [TOP_W-1:0]         top_bits;

  assign p_lo = WIDE_W'($signed(prod[0]));
  assign p_hi = WIDE_W'($signed(prod[1]));

  always_comb begin
    acc_wide = ctrl.acc_en ? WIDE_W'($signed(acc)) : '0;
    pair     = ctrl.sub_sel ? (p_lo - p_hi) : (p_lo + p_hi);
    total    = pair + acc_wide;
    top_bits = total[WIDE_W-1:DATA_W-1];
    ovf      = ~((&top_bits) | ~(|top_bits));
    sum_out  = total[DATA_W-1:0];
  end

  // R3: the difference of two half products always fits the word
  always_comb begin
    if (ctrl.sub_sel && !ctrl.acc_en) begin
      p_sub_noovf_r3: assert (!ovf);
    end
  end

endmodule

// File: rtl/dual_mac16.sv
module dual_mac16
  import dmac_pkg::*;
#(
  parameter int HALF_W = 16,
  localparam int DATA_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_in,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [DATA_W-1:0] acc,
  input  logic              acc_en,
  input  logic              swap_b,
  input  logic              sub_sel,
  input  logic              q_in,
  output logic              valid_out,
  output logic [DATA_W-1:0] result,
  output logic              q_out
);

  logic                   rst_sync_n;
  logic [1:0][DATA_W-1:0] prod;
  logic [DATA_W-1:0]      sum_w;
  logic                   ovf_w;
  dmac_ctrl_t             ctrl;

  logic              vld_q, vld_d;
  logic [DATA_W-1:0] res_q, res_d;
  logic              flag_q, flag_d;

  assign ctrl = '{acc_en: acc_en, swap_b: swap_b, sub_sel: sub_sel};

  dmac_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dmac_prod #(.HALF_W(HALF_W)) u_prod (
    .opa    (opa),
    .opb    (opb),
    .swap_b (ctrl.swap_b),
    .prod   (prod)
  );

  dmac_sum #(.DATA_W(DATA_W)) u_sum (
    .prod    (prod),
    .acc     (acc),
    .ctrl    (ctrl),
    .sum_out (sum_w),
    .ovf     (ovf_w)
  );

  // next state with explicit enable
  always_comb begin
    vld_d  = valid_in;
    res_d  = res_q;
    flag_d = flag_q;
    if (valid_in) begin
      res_d  = sum_w;
      flag_d = q_in | ovf_w;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q  <= 1'b0;
      res_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      vld_q  <= vld_d;
      res_q  <= res_d;
      flag_q <= flag_d;
    end
  end

  assign valid_out = vld_q;
  assign result    = res_q;
  assign q_out     = flag_q;

  p_valid_lat_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    valid_in |=> valid_out);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !valid_in |=> ($stable(result) && $stable(q_out) && !valid_out));

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (valid_in && q_in) |=> q_out);

  p_sub_q_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (valid_in && sub_sel && !acc_en) |=> (q_out == $past(q_in)));

endmodule

// File: tb/test_dual_mac16.sv
module test_dual_mac16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_in = 1'b0;
  logic [31:0] opa = '0, opb = '0, acc = '0;
  logic        acc_en = 1'b0, swap_b = 1'b0, sub_sel = 1'b0, q_in = 1'b0;
  logic        valid_out;
  logic [31:0] result;
  logic        q_out;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  dual_mac16 i_dual_mac16 (
    .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .opa(opa), .opb(opb),
    .acc(acc), .acc_en(acc_en), .swap_b(swap_b), .sub_sel(sub_sel),
    .q_in(q_in), .valid_out(valid_out), .result(result), .q_out(q_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void model(input logic [31:0] a, b, c, input bit ae, sw, sb,
                                output logic [31:0] r, output bit ov);
    logic [31:0] bb;
    longint p0, p1, s;
    bb = sw ? {b[15:0], b[31:16]} : b;
    p0 = longint'(shortint'(a[15:0])) * longint'(shortint'(bb[15:0]));
    p1 = longint'(shortint'(a[31:16])) * longint'(shortint'(bb[31:16]));
    s  = sb ? p0 - p1 : p0 + p1;
    if (ae) s = s + longint'(int'(c));
    r  = s[31:0];
    ov = (s > 64'sd2147483647) || (s < -64'sd2147483648);
  endfunction

  // one operation; checks valid, result and flag one cycle later
  task automatic run_op(input string req, input logic [31:0] a, b, c,
                        input bit ae, sw, sb, qi);
    logic [31:0] er;
    bit eo;
    model(a, b, c, ae, sw, sb, er, eo);
    @(negedge clk);
    valid_in = 1'b1; opa = a; opb = b; acc = c;
    acc_en = ae; swap_b = sw; sub_sel = sb; q_in = qi;
    @(negedge clk);
    valid_in = 1'b0;
    check({req, " valid"}, {31'd0, valid_out}, 32'd1);
    check({req, " result"}, result, er);
    check({req, " flag"}, {31'd0, q_out}, {31'd0, qi | eo});
  endtask

  task automatic t_reset;
    check("R10 valid", {31'd0, valid_out}, 32'd0);
    check("R10 result", result, 32'd0);
    check("R10 flag", {31'd0, q_out}, 32'd0);
  endtask

  task automatic t_basic;
    run_op("R1 add", 32'h0003_0005, 32'h0007_000B, 32'd0, 0, 0, 0, 0);
    check("R1 value", result, 32'd76);
    run_op("R1 signs", 32'hFFFE_0004, 32'h0003_FFF9, 32'd0, 0, 0, 0, 0);
  endtask

  task automatic t_swap;
    run_op("R2 swap", 32'h0003_0005, 32'h0007_000B, 32'd0, 0, 1, 0, 0);
    check("R2 value", result, 32'd68);
  endtask

  task automatic t_sub;
    run_op("R3 sub", 32'h0003_0005, 32'h0007_000B, 32'd0, 0, 0, 1, 0);
    check("R3 value", result, 32'd34);
    run_op("R3 extreme", 32'h7FFF_8000, 32'h8000_8000, 32'd0, 0, 0, 1, 0);
  endtask

  task automatic t_sub_acc;
    run_op("R4 ovf", 32'h0000_8000, 32'h0000_8000, 32'h7FFF_FFFF, 1, 0, 1, 0);
    check("R4 flag set", {31'd0, q_out}, 32'd1);
    run_op("R4 fit", 32'h0000_8000, 32'h0000_8000, 32'h0000_0010, 1, 0, 1, 0);
    check("R4 flag clear", {31'd0, q_out}, 32'd0);
  endtask

  task automatic t_add_ovf;
    run_op("R5 ovf", 32'h8000_8000, 32'h8000_8000, 32'd0, 0, 0, 0, 0);
    check("R5 flag set", {31'd0, q_out}, 32'd1);
    check("R5 value", result, 32'h8000_0000);
  endtask

  task automatic t_corner;
    run_op("R6 corner", 32'h8000_8000, 32'h8000_8000, 32'hFFFF_FFFF, 1, 0, 0, 0);
    check("R6 value", result, 32'h7FFF_FFFF);
    check("R6 no flag", {31'd0, q_out}, 32'd0);
    run_op("R6 over", 32'h8000_8000, 32'h8000_8000, 32'h0000_0001, 1, 0, 0, 0);
  endtask

  task automatic t_acc_ignored;
    run_op("R7 ignored", 32'h8000_8000, 32'h8000_8000, 32'hFFFF_FFFF, 0, 0, 0, 0);
    check("R7 value", result, 32'h8000_0000);
  endtask

  task automatic t_sticky;
    run_op("R8 sticky", 32'h0001_0001, 32'h0001_0001, 32'd0, 0, 0, 0, 1);
    check("R8 held", {31'd0, q_out}, 32'd1);
  endtask

  task automatic t_hold;
    logic [31:0] keep;
    logic kq;
    keep = result; kq = q_out;
    @(negedge clk);
    opa = 32'h1234_5678; opb = 32'h8000_8000; acc = 32'h7FFF_FFFF;
    acc_en = 1; sub_sel = 0; q_in = 1;
    @(negedge clk);
    @(negedge clk);
    check("R9 no valid", {31'd0, valid_out}, 32'd0);
    check("R9 result held", result, keep);
    check("R9 flag held", {31'd0, q_out}, {31'd0, kq});
  endtask

  function automatic logic [15:0] pick(input int unsigned s);
    case (s % 4)
      0:       pick = 16'h8000;
      1:       pick = 16'h7FFF;
      2:       pick = 16'hFFFF;
      default: pick = 16'($urandom);
    endcase
  endfunction

  task automatic t_random;
    for (int i = 0; i < 300; i++) begin
      logic [31:0] a, b, c;
      int unsigned k;
      k = $urandom;
      a = {pick($urandom), pick($urandom)};
      b = {pick($urandom), pick($urandom)};
      c = (k[8]) ? {pick($urandom), pick($urandom)} : 32'($urandom);
      run_op("R1/R2/R3/R4/R5/R6 random", a, b, c, k[0], k[1], k[2], k[3]);
    end
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic();
    t_swap();
    t_sub();
    t_sub_acc();
    t_add_ovf();
    t_corner();
    t_acc_ignored();
    t_sticky();
    t_hold();
    t_random();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule